// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Data Memory Port

This block sits behind the load/store stage of a processor and owns a private RAM whose size is set by a parameter. A request carries an address, a size code (byte, halfword or word), a read/write flag and a write value. Every request is screened before the RAM is touched. An address at or beyond the end of the RAM is refused with a range status. An aligned address is required for halfword and word sizes, and a misaligned one is refused with an alignment status. A refused request never changes the RAM, and a refused read returns zero.

A level input picks big-endian or little-endian byte order for each request. In big-endian order the most significant byte of a word or halfword sits at the lowest address. In little-endian order the least significant byte sits there. The RAM is built as four byte-wide banks, one per address offset within a word. The byte order only changes which bank receives or supplies which byte of the value, so data written in one order can be read back in the other.

Once reset is released, the block sweeps zeros through every RAM location, one word per cycle, and refuses requests (ready low) until the sweep is over. After that, every request is accepted on the cycle it is presented. A response with zero-extended read data and a 2-bit status follows exactly one cycle later. The RAM holds 2^MEM_LOG2 bytes. The default is kept small, and the 8 MiB configuration is reached with MEM_LOG2 = 23.

Top module: `dmem_port`

## Requirements
- R1: While rst_n is low, req_ready and rsp_valid are 0. After rst_n rises, req_ready stays 0 for exactly 2^MEM_LOG2/4 rising clock edges while every word is cleared. Afterwards every location reads as zero and req_ready is 1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. On the next cycle rsp_valid is 1 with that request's status, and rsp_valid is 0 in any cycle not preceded by an acceptance. The status encodings are 0 OK, 1 range fault and 2 alignment fault; the value 3 never occurs.
- R3: An access whose unsigned address is at least 2^MEM_LOG2 reports status 1, changes no RAM byte (the address is not wrapped onto a lower location) and, for a read, returns rsp_rdata 0.
- R4: A word access (req_size 2 or 3) in range with req_addr[1:0] not 00 reports status 2, leaves the RAM unchanged and returns 0.
- R5: A halfword access (req_size 1) in range with req_addr[0] = 1 reports status 2 and leaves the RAM unchanged. A byte access (req_size 0) in range always reports status 0.
- R6: An access that is both out of range and misaligned reports status 1, not 2.
- R7: With big_endian = 1, a word write places value bits 31:24 at address A, 23:16 at A+1, 15:8 at A+2 and 7:0 at A+3. A read assembles the bytes the same way. A halfword places bits 15:8 at A and 7:0 at A+1.
- R8: With big_endian = 0, a word write places bits 7:0 at A, 15:8 at A+1, 23:16 at A+2 and 31:24 at A+3. A halfword places bits 7:0 at A and 15:8 at A+1, and reads assemble the same way.
- R9: A byte write changes exactly the addressed byte, using value bits 7:0. A halfword write changes exactly its two bytes. All other bytes keep their contents.
- R10: Read data is zero-extended: a byte read drives rsp_rdata bits 31:8 to 0 and a halfword read drives bits 31:16 to 0. A write response carries rsp_rdata 0. req_size 3 behaves exactly as req_size 2 (word).
- R11: big_endian is applied per request and never alters stored bytes. A word written in one order and read in the other comes back byte-reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order for the presented request: 1 big-endian, 0 little-endian |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block accepts a request this cycle (0 during the clear sweep) |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write value, right-aligned for byte and halfword |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_rdata | output | 32 | Zero-extended read data; 0 for writes and faults |
| rsp_status | output | 2 | 0 OK, 1 range fault, 2 alignment fault |

## Verification
The properties assume that the request fields are stable and known while req_valid is high. They also assume a response is always consumed, since the block offers no way to hold one back. The status properties decode the size and address fields straight from the ports, so they expect req_size and req_addr to be meaningful only on an accepted edge. The stimulus drives all request fields together on the falling edge and keeps them steady across the next rising edge. It also raises req_valid only once the clear sweep has ended, apart from a deliberately ignored idle pattern with req_valid low and random address and data.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int LANES = 4;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_RANGE = 2'd1,
    ST_ALIGN = 2'd2
  } status_e;

  typedef logic [LANES-1:0][7:0] lanes_t;

  // Range first, then natural alignment of the access size.
  function automatic status_e classify(input logic beyond, input logic [1:0] sz,
                                       input logic [1:0] off);
    if (beyond) return ST_RANGE;
    if (sz == SZ_HALF && off[0]) return ST_ALIGN;
    if (sz[1] && off != 2'b00) return ST_ALIGN;
    return ST_OK;
  endfunction

  // Banks touched by an access of size sz at word offset off.
  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: return 4'b0001 << off;
      SZ_HALF: return 4'b0011 << {off[1], 1'b0};
      default: return 4'b1111;
    endcase
  endfunction

  // Which byte of the write value lands in bank 'lane'.
  function automatic logic [1:0] src_byte(input logic [1:0] sz, input logic [1:0] lane,
                                          input logic big);
    case (sz)
      SZ_BYTE: return 2'd0;
      SZ_HALF: return {1'b0, big ? ~lane[0] : lane[0]};
      default: return big ? ~lane : lane;
    endcase
  endfunction

  // Which bank supplies byte 'pos' of the read result.
  function automatic logic [1:0] src_lane(input logic [1:0] sz, input logic [1:0] off,
                                          input logic [1:0] pos, input logic big);
    case (sz)
      SZ_BYTE: return off;
      SZ_HALF: return {off[1], big ? ~pos[0] : pos[0]};
      default: return big ? ~pos : pos;
    endcase
  endfunction

  // Result bytes that carry data; the rest are zero-extended.
  function automatic logic [3:0] keep_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 4'b0001;
      SZ_HALF: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/dmem_screen.sv
module dmem_screen
  import dmem_pkg::*;
#(
  parameter int HI_W = 22
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [1:0]      size,
  input  logic [1:0]      off,
  output status_e         status,
  output logic            ok
);

  logic beyond;

  assign beyond = |addr_hi;
  assign status = classify(beyond, size, off);
  assign ok     = (status == ST_OK);

endmodule

// File: rtl/dmem_steer.sv
module dmem_steer
  import dmem_pkg::*;
(
  input  logic        go,
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic        big,
  input  logic [31:0] wdata,
  output logic [3:0]  lane_we,
  output lanes_t      lane_wd
);

  logic [3:0] mask;

  assign mask = lane_mask(size, off);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] pick;
    assign pick       = src_byte(size, 2'(k), big);
    assign lane_we[k] = go & mask[k];
    assign lane_wd[k] = wdata[{pick, 3'b000} +: 8];
  end

endmodule

// File: rtl/dmem_gather.sv
module dmem_gather
  import dmem_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic        big,
  input  lanes_t      lane_rd,
  output logic [31:0] word
);

  logic [3:0] keep;

  assign keep = keep_mask(size);

  for (genvar j = 0; j < LANES; j++) begin : g_pos
    logic [1:0] from;
    assign from          = src_lane(size, off, 2'(j), big);
    assign word[8*j +: 8] = keep[j] ? lane_rd[from] : 8'h00;
  end

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wd,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd
);

  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wr_idx] <= wd;
  end

  assign rd = cells[rd_idx];

endmodule

// File: rtl/dmem_port.sv
module dmem_port
  import dmem_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MEM_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        rsp_status
);

  localparam int IDX_W = MEM_LOG2 - 2;
  localparam int HI_W  = ADDR_W - MEM_LOG2;

  // Named internal events, observed by the bound checker.
  logic             clearing;
  logic [IDX_W-1:0] clr_idx;
  logic             acc_fire;
  status_e          acc_status;
  logic             acc_ok;
  logic [3:0]       lane_we;
  lanes_t           lane_wd;
  lanes_t           lane_rd;
  logic [31:0]      rd_word;
  logic [IDX_W-1:0] req_idx;
  logic [1:0]       req_off;

  assign req_idx   = req_addr[MEM_LOG2-1:2];
  assign req_off   = req_addr[1:0];
  assign req_ready = ~clearing;
  assign acc_fire  = req_valid & req_ready;

  // Zero sweep after reset, one word index per cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == {IDX_W{1'b1}}) clearing <= 1'b0;
    end
  end

  dmem_screen #(.HI_W(HI_W)) u_screen (
    .addr_hi (req_addr[ADDR_W-1:MEM_LOG2]),
    .size    (req_size),
    .off     (req_off),
    .status  (acc_status),
    .ok      (acc_ok)
  );

  dmem_steer u_steer (
    .go      (acc_fire & req_write & acc_ok),
    .size    (req_size),
    .off     (req_off),
    .big     (big_endian),
    .wdata   (req_wdata),
    .lane_we (lane_we),
    .lane_wd (lane_wd)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic             b_we;
    logic [IDX_W-1:0] b_idx;
    logic [7:0]       b_wd;

    assign b_we  = clearing | lane_we[k];
    assign b_idx = clearing ? clr_idx : req_idx;
    assign b_wd  = clearing ? 8'h00 : lane_wd[k];

    dmem_bank #(.IDX_W(IDX_W)) u_bank (
      .clk    (clk),
      .we     (b_we),
      .wr_idx (b_idx),
      .wd     (b_wd),
      .rd_idx (req_idx),
      .rd     (lane_rd[k])
    );
  end

  dmem_gather u_gather (
    .size    (req_size),
    .off     (req_off),
    .big     (big_endian),
    .lane_rd (lane_rd),
    .word    (rd_word)
  );

  // Response register: one cycle after acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_status <= ST_OK;
    end else begin
      rsp_valid <= acc_fire;
      if (acc_fire) begin
        rsp_status <= acc_status;
        rsp_rdata  <= (acc_ok && !req_write) ? rd_word : 32'h0;
      end
    end
  end

endmodule

// File: rtl/dmem_port_chk.sv
module dmem_port_chk #(
  parameter int ADDR_W   = 32,
  parameter int MEM_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [1:0]        rsp_status,
  input logic              acc_fire,
  input logic [1:0]        acc_status,
  input logic [3:0]        lane_we,
  input logic              clearing
);

  logic beyond;
  assign beyond = (req_addr >> MEM_LOG2) != '0;

  assert_clear_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !req_ready);

  assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);

  assert_range_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && beyond) |=> rsp_status == 2'd1);

  assert_fault_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_status != 2'd0) |-> lane_we == 4'b0000);

  assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !beyond && req_size[1] && req_addr[1:0] != 2'b00) |=> rsp_status == 2'd2);

  assert_half_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !beyond && req_size == 2'd1 && req_addr[0]) |=> rsp_status == 2'd2);

  assert_byte_never_misaligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !beyond && req_size == 2'd0) |=> rsp_status == 2'd0);

  assert_range_over_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && beyond && req_addr[0] && req_size != 2'd0) |=> rsp_status == 2'd1);

  assert_byte_lane_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_write && req_size == 2'd0 && acc_status == 2'd0) |-> $countones(lane_we) == 1);

  assert_half_lane_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_write && req_size == 2'd1 && acc_status == 2'd0) |-> $countones(lane_we) == 2);

  assert_fault_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> rsp_rdata == 32'h0);

  assert_write_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_write) |=> rsp_rdata == 32'h0);

endmodule

bind dmem_port dmem_port_chk #(.ADDR_W(ADDR_W), .MEM_LOG2(MEM_LOG2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_status (rsp_status),
  .acc_fire   (acc_fire),
  .acc_status (acc_status),
  .lane_we    (lane_we),
  .clearing   (clearing)
);

// File: tb/tb_dmem_port.sv
module tb_dmem_port;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int MEM_LOG2   = 10;
  localparam int MEM_BYTES  = 1 << MEM_LOG2;
  localparam int MEM_WORDS  = MEM_BYTES / 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              big_endian = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [1:0]        rsp_status;

  dmem_port #(.ADDR_W(ADDR_W), .MEM_LOG2(MEM_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference: flat byte array plus the expected response.
  logic [7:0]  model [MEM_BYTES];
  bit          exp_v = 0;
  logic [31:0] exp_rdata = '0;
  logic [1:0]  exp_status = '0;
  string       exp_tag = "R2";

  task automatic model_access(input bit w, input logic [1:0] sz, input logic [31:0] a,
                              input logic [31:0] wd, input bit be,
                              output logic [31:0] rd, output logic [1:0] st);
    int n;
    n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    rd = '0;
    if (a >= 32'(MEM_BYTES)) st = 2'd1;
    else if ((a % 32'(n)) != 0) st = 2'd2;
    else st = 2'd0;
    if (st == 2'd0) begin
      for (int i = 0; i < n; i++) begin
        int sh;
        sh = be ? (n - 1 - i) : i;
        if (w) model[int'(a) + i] = wd[8*sh +: 8];
        else   rd = rd | (32'(model[int'(a) + i]) << (8*sh));
      end
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, input bit be, input string tag);
    @(negedge clk);
    req_valid  = v;
    req_write  = w;
    req_size   = sz;
    req_addr   = a;
    req_wdata  = wd;
    big_endian = be;
    exp_v      = v && (req_ready === 1'b1);
    exp_tag    = tag;
    if (exp_v) model_access(w, sz, a, wd, be, exp_rdata, exp_status);
  endtask

  task automatic idle();
    step(0, 1, 2'd2, $urandom, $urandom, 1'b1, "R2");
  endtask

  task automatic check(input bit ok, input string what, input logic [31:0] got,
                       input logic [31:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, want);
    end
  endtask

  // Compare against the reference on every clock, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      check(rsp_valid === exp_v, {exp_tag, " rsp_valid"}, 32'(rsp_valid), 32'(exp_v));
      if (exp_v) begin
        check(rsp_status === exp_status, {exp_tag, " rsp_status"}, 32'(rsp_status), 32'(exp_status));
        check(rsp_rdata === exp_rdata, {exp_tag, " rsp_rdata"}, rsp_rdata, exp_rdata);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'h00;

    // R1: reset state
    repeat (2) @(negedge clk);
    check(req_ready === 1'b0, "R1 ready in reset", 32'(req_ready), 32'd0);
    check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    cnt = 0;
    while (req_ready !== 1'b1 && cnt < 4 * MEM_WORDS) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == MEM_WORDS, "R1 clear sweep length", 32'(cnt), 32'(MEM_WORDS));

    // R1: cleared contents
    step(1, 0, 2'd2, 32'h0, 0, 1, "R1");
    step(1, 0, 2'd2, 32'h4, 0, 1, "R1");
    step(1, 0, 2'd2, 32'(MEM_BYTES - 4), 0, 0, "R1");

    // R7: big-endian word layout
    step(1, 1, 2'd2, 32'h10, 32'h11223344, 1, "R7");
    step(1, 0, 2'd2, 32'h10, 0, 1, "R7");
    step(1, 0, 2'd0, 32'h10, 0, 1, "R7");
    step(1, 0, 2'd0, 32'h13, 0, 1, "R7");
    step(1, 0, 2'd1, 32'h12, 0, 1, "R7");
    // R11: read the same word in the other order
    step(1, 0, 2'd2, 32'h10, 0, 0, "R11");

    // R8: little-endian word and halfword
    step(1, 1, 2'd2, 32'h20, 32'hA1B2C3D4, 0, "R8");
    step(1, 0, 2'd0, 32'h20, 0, 0, "R8");
    step(1, 1, 2'd1, 32'h22, 32'h0000BEEF, 0, "R8");
    step(1, 0, 2'd2, 32'h20, 0, 0, "R8");
    step(1, 0, 2'd1, 32'h22, 0, 1, "R11");

    // R9: byte and halfword writes preserve neighbours
    step(1, 1, 2'd0, 32'h31, 32'hFFFFFF5A, 1, "R9");
    step(1, 0, 2'd2, 32'h30, 0, 1, "R9");
    step(1, 1, 2'd1, 32'h32, 32'hFFFF1234, 1, "R9");
    step(1, 0, 2'd2, 32'h30, 0, 1, "R9");
    step(1, 1, 2'd0, 32'h30, 32'h000000C7, 0, "R9");
    step(1, 0, 2'd2, 32'h30, 0, 0, "R9");

    // R10: zero extension, size 3 as word
    step(1, 0, 2'd0, 32'h30, 0, 1, "R10");
    step(1, 0, 2'd1, 32'h30, 0, 0, "R10");
    step(1, 1, 2'd3, 32'h40, 32'hCAFEF00D, 1, "R10");
    step(1, 0, 2'd2, 32'h40, 0, 1, "R10");
    step(1, 0, 2'd3, 32'h40, 0, 0, "R10");

    // R4: misaligned words fault and do not write
    step(1, 1, 2'd2, 32'h11, 32'hDEADBEEF, 1, "R4");
    step(1, 1, 2'd3, 32'h12, 32'hDEADBEEF, 0, "R4");
    step(1, 0, 2'd2, 32'h13, 0, 1, "R4");
    step(1, 0, 2'd2, 32'h10, 0, 1, "R4");

    // R5: misaligned halfwords fault, bytes never do
    step(1, 1, 2'd1, 32'h21, 32'h00009999, 0, "R5");
    step(1, 0, 2'd1, 32'h23, 0, 1, "R5");
    step(1, 0, 2'd2, 32'h20, 0, 0, "R5");
    step(1, 0, 2'd0, 32'h23, 0, 0, "R5");
    step(1, 1, 2'd0, 32'h2F, 32'h000000AB, 0, "R5");
    step(1, 0, 2'd0, 32'h2F, 0, 1, "R5");

    // R3: out of range, no wrap onto low addresses
    step(1, 0, 2'd2, 32'(MEM_BYTES), 0, 1, "R3");
    step(1, 1, 2'd2, 32'(MEM_BYTES), 32'h55AA55AA, 1, "R3");
    step(1, 1, 2'd0, 32'(MEM_BYTES + 16), 32'h000000EE, 1, "R3");
    step(1, 0, 2'd2, 32'h0, 0, 1, "R3");
    step(1, 0, 2'd2, 32'h10, 0, 1, "R3");
    step(1, 0, 2'd2, 32'hFFFFFFFC, 0, 0, "R3");
    step(1, 1, 2'd1, 32'h80000000, 32'h1234, 0, "R3");

    // R6: range beats alignment
    step(1, 0, 2'd2, 32'(MEM_BYTES + 1), 0, 1, "R6");
    step(1, 1, 2'd1, 32'hFFFFFFFF, 32'h1111, 0, "R6");
    step(1, 0, 2'd3, 32'(MEM_BYTES + 2), 0, 0, "R6");

    // R2: idle patterns are ignored, then mixed traffic with gaps
    idle();
    idle();
    step(1, 0, 2'd2, 32'h10, 0, 1, "R2");
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 6 == 0) idle();
      else begin
        logic [31:0] a;
        if ($urandom % 10 == 0) a = $urandom;
        else a = $urandom % MEM_BYTES;
        step(1, 1'($urandom), 2'($urandom), a, $urandom, 1'($urandom), "R2");
      end
    end
    idle();
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule